// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises a processor by watching its periodic service events ("kicks"). A kick is valid only when it arrives inside a window measured from the previous accepted kick. The window opens at a lower limit and closes at an upper limit. A kick that comes too soon raises a reset request. So does a missing kick once the upper limit is reached. A runaway loop that kicks at a high rate therefore cannot keep the system alive.

The counter runs on a dedicated watchdog clock, independent of the processor clock. A processor clock that slows down by a large factor still produces a late fault. The kick and the processor-halted indication arrive asynchronously and are synchronized into the watchdog domain. While the processor is halted, the count freezes and no fault is raised. A fault produces a registered reset pulse of fixed length and records its cause for later inspection.

The window limits are loaded through a configuration strobe and are checked before they are accepted. With the default parameters (24-bit counter, close limit 3277) and a 32.768 kHz watchdog clock, the window closes after 100 ms.

Top module: `win_watchdog`

## Requirements
- R1: When no kick is taken and the count equals or exceeds the close limit, the next edge raises `wd_reset` and sets `fault_cause` to 2'b10 (late).
- R2: A kick taken while the count is below the open limit raises `wd_reset` on that edge and sets `fault_cause` to 2'b01 (early).
- R3: A kick taken with the count from the open limit to the close limit inclusive is accepted. It raises no reset and restarts the count from zero, so the count seen at an edge is one less than the number of edges since the acceptance edge.
- R4: `kick_in` is an asynchronous level. Each rising edge yields exactly one service event, however long the level is held. The event acts on the third watchdog-clock edge after the rise. The level must stay high for at least 2 cycles and low for at least 2 cycles.
- R5: While the synchronized `halt_in` is high, the count is frozen and no new fault is raised. A late fault is delayed by exactly the number of halted edges. `halt_in` passes through 2 flops, so it takes effect from the third edge after it rises.
- R6: `wd_reset` is a registered pulse of exactly PULSE (16) cycles. During the pulse the count is held at zero, and the first edge after the pulse counts from zero.
- R7: `fault_cause` (00 none, 01 early, 10 late) keeps its value after the pulse and while disabled. It is cleared to 00 on the first edge where `enable` is seen high after being low.
- R8: A configuration strobe loads the limits only when `cfg_open` < `cfg_close`, and clears `cfg_error`. Otherwise the limits are kept and `cfg_error` is set.
- R9: While `enable` is low, the count is held at zero and `wd_reset` is low from the first edge where `enable` is low, including in the middle of a pulse.
- R10: After `wd_rst_n` the outputs are `wd_reset`=0, `fault_cause`=00 and `cfg_error`=0, and the limits equal DEF_OPEN and DEF_CLOSE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wd_clk | input | 1 | Independent watchdog clock |
| wd_rst_n | input | 1 | Active-low reset, watchdog domain |
| kick_in | input | 1 | Asynchronous service level from the processor |
| halt_in | input | 1 | Asynchronous processor-halted indication |
| enable | input | 1 | Watchdog enable |
| cfg_load | input | 1 | Strobe that loads the window limits |
| cfg_open | input | CW | Lower window limit in watchdog cycles |
| cfg_close | input | CW | Upper window limit in watchdog cycles |
| wd_reset | output | 1 | Registered reset request pulse |
| fault_cause | output | 2 | Last fault cause: 00 none, 01 early, 10 late |
| cfg_error | output | 1 | Last configuration was rejected |

## Verification
The bench builds the block with CW=8, PULSE=16, DEF_OPEN=6 and DEF_CLOSE=12. These settings keep a whole window, including the late case, within a few dozen cycles. The bench sweeps the kick spacing over every value from the shortest legal spacing to past the close limit. Each spacing is predicted as early, accepted or late from the count arithmetic. With windows this short, the halt shift, the pulse length with its restart, and a second set of limits loaded at run time can all be checked to the exact edge.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int CW        = 24,
  parameter int PULSE     = 16,
  parameter int DEF_OPEN  = 1638,
  parameter int DEF_CLOSE = 3277
) (
  input  logic          wd_clk,
  input  logic          wd_rst_n,
  input  logic          kick_in,
  input  logic          halt_in,
  input  logic          enable,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_open,
  input  logic [CW-1:0] cfg_close,
  output logic          wd_reset,
  output logic [1:0]    fault_cause,
  output logic          cfg_error
);
  localparam int PW = $clog2(PULSE + 1);
  localparam logic [1:0] CAUSE_NONE  = 2'b00;
  localparam logic [1:0] CAUSE_EARLY = 2'b01;
  localparam logic [1:0] CAUSE_LATE  = 2'b10;

  logic [2:0]    kick_s;
  logic [1:0]    halt_s;
  logic          en_q;
  logic [CW-1:0] cnt, lim_open, lim_close;
  logic [PW-1:0] left;
  logic          trip;
  logic [1:0]    trip_code;

  wire kick_evt = kick_s[1] & ~kick_s[2];
  wire halted   = halt_s[1];

  always_ff @(posedge wd_clk or negedge wd_rst_n)
    if (!wd_rst_n) begin
      kick_s <= '0;
      halt_s <= '0;
    end else begin
      kick_s <= {kick_s[1:0], kick_in};
      halt_s <= {halt_s[0], halt_in};
    end

  always_comb begin
    trip      = 1'b0;
    trip_code = CAUSE_NONE;
    if (!halted) begin
      if (kick_evt) begin
        if (cnt < lim_open) begin
          trip = 1'b1;  trip_code = CAUSE_EARLY;
        end else if (cnt > lim_close) begin
          trip = 1'b1;  trip_code = CAUSE_LATE;
        end
      end else if (cnt >= lim_close) begin
        trip = 1'b1;  trip_code = CAUSE_LATE;
      end
    end
  end

  always_ff @(posedge wd_clk or negedge wd_rst_n)
    if (!wd_rst_n) begin
      lim_open  <= CW'(DEF_OPEN);
      lim_close <= CW'(DEF_CLOSE);
      cfg_error <= 1'b0;
    end else if (cfg_load) begin
      if (cfg_open < cfg_close) begin
        lim_open  <= cfg_open;
        lim_close <= cfg_close;
        cfg_error <= 1'b0;
      end else begin
        cfg_error <= 1'b1;
      end
    end

  always_ff @(posedge wd_clk or negedge wd_rst_n)
    if (!wd_rst_n) begin
      en_q        <= 1'b0;
      cnt         <= '0;
      left        <= '0;
      wd_reset    <= 1'b0;
      fault_cause <= CAUSE_NONE;
    end else begin
      en_q <= enable;
      if (!enable) begin
        cnt      <= '0;
        left     <= '0;
        wd_reset <= 1'b0;
      end else begin
        if (!en_q) fault_cause <= CAUSE_NONE;
        if (wd_reset) begin
          cnt <= '0;
          if (left == '0) wd_reset <= 1'b0;
          else            left     <= left - 1'b1;
        end else if (trip) begin
          wd_reset    <= 1'b1;
          left        <= PW'(PULSE - 1);
          fault_cause <= trip_code;
          cnt         <= '0;
        end else if (!halted) begin
          cnt <= kick_evt ? '0 : cnt + 1'b1;
        end
      end
    end
endmodule

module win_watchdog_chk #(
  parameter int CW    = 24,
  parameter int PULSE = 16
) (
  input logic          wd_clk,
  input logic          wd_rst_n,
  input logic          enable,
  input logic          halted,
  input logic          kick_evt,
  input logic          cfg_load,
  input logic [CW-1:0] cfg_open,
  input logic [CW-1:0] cfg_close,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lim_open,
  input logic [CW-1:0] lim_close,
  input logic          wd_reset,
  input logic [1:0]    fault_cause,
  input logic          cfg_error
);
  logic [15:0] hi_cnt;
  always_ff @(posedge wd_clk or negedge wd_rst_n)
    if (!wd_rst_n)     hi_cnt <= '0;
    else if (wd_reset) hi_cnt <= hi_cnt + 1'b1;
    else               hi_cnt <= '0;

  p_late_trip_r1: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    enable && !wd_reset && !halted && !kick_evt && cnt >= lim_close |=> wd_reset && fault_cause == 2'b10);

  p_early_trip_r2: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    enable && !wd_reset && !halted && kick_evt && cnt < lim_open |=> wd_reset && fault_cause == 2'b01);

  p_accept_restart_r3: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    enable && !wd_reset && !halted && kick_evt && cnt >= lim_open && cnt <= lim_close |=> !wd_reset && cnt == '0);

  p_single_event_r4: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    kick_evt |=> !kick_evt);

  p_halt_quiet_r5: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    halted && !wd_reset |=> !wd_reset && $stable(cnt));

  p_pulse_len_r6: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    $fell(wd_reset) && $past(enable) |-> hi_cnt == PULSE);

  p_pulse_max_r6: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    wd_reset |-> hi_cnt < PULSE);

  p_cause_change_r7: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    !$stable(fault_cause) |-> $rose(wd_reset) || fault_cause == 2'b00);

  p_cause_legal_r7: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    fault_cause != 2'b11);

  p_cfg_reject_r8: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    cfg_load && cfg_open >= cfg_close |=> cfg_error && $stable(lim_open) && $stable(lim_close));

  p_limit_order_r8: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    lim_open < lim_close);

  p_disabled_r9: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    !enable |=> !wd_reset && cnt == '0);
endmodule

bind win_watchdog win_watchdog_chk #(.CW(CW), .PULSE(PULSE)) u_chk (
  .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .enable(enable), .halted(halted),
  .kick_evt(kick_evt), .cfg_load(cfg_load), .cfg_open(cfg_open), .cfg_close(cfg_close),
  .cnt(cnt), .lim_open(lim_open), .lim_close(lim_close), .wd_reset(wd_reset),
  .fault_cause(fault_cause), .cfg_error(cfg_error)
);

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;
  localparam int CW = 8;
  localparam int PULSE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0, halt = 1'b0, en = 1'b0, load = 1'b0;
  logic [CW-1:0] c_open = '0, c_close = '0;
  logic wd_reset, cfg_error;
  logic [1:0] fault_cause;

  int checks = 0, errors = 0;
  logic [1:0] last_cause = 2'b00;
  bit done = 0;

  always #10 clk = ~clk;

  win_watchdog #(.CW(CW), .PULSE(PULSE), .DEF_OPEN(6), .DEF_CLOSE(12)) u_win_watchdog (
    .wd_clk(clk), .wd_rst_n(rst_n), .kick_in(kick), .halt_in(halt), .enable(en),
    .cfg_load(load), .cfg_open(c_open), .cfg_close(c_close),
    .wd_reset(wd_reset), .fault_cause(fault_cause), .cfg_error(cfg_error));

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // d: spacing in edges from anchor raise to second kick raise (d>=99: no kick)
  task automatic trial(input int d, input int hold, input int lo, input int hi,
                       input int hstart, input int hlen, input string req);
    int f, ecause;
    bit acc;
    en = 1'b0; kick = 1'b0;
    tick(); tick(); tick();
    chk(fault_cause == last_cause, "R7", "cause held while disabled", fault_cause, last_cause);
    en = 1'b1;
    acc = (d - 1 >= lo) && (d - 1 <= hi) && (d < 99);
    if (d - 1 < lo)  begin f = d;          ecause = 1; end
    else if (acc)    begin f = d + hi + 1; ecause = 2; end
    else             begin f = hi + 1 + hlen; ecause = 2; end
    for (int r = -8; r < f; r++) begin
      kick = (r == -3 || r == -2) || (d < 99 && r >= d - 3 && r < d - 3 + hold);
      halt = (hlen > 0) && (r >= hstart) && (r < hstart + hlen);
      if (r == -7) chk(fault_cause == 2'b00, "R7", "cause cleared on enable", fault_cause, 0);
      if (r == f - 1) chk(wd_reset == 1'b0, req, "no reset before fault edge", wd_reset, 0);
      if (acc && r == d + 1) chk(wd_reset == 1'b0, "R3", "in-window kick accepted", wd_reset, 0);
      if (hlen > 0 && r == hi + 1) chk(wd_reset == 1'b0, "R5", "no fault while halted", wd_reset, 0);
      tick();
    end
    kick = 1'b0; halt = 1'b0;
    chk(wd_reset == 1'b1, req, "reset raised at fault edge", wd_reset, 1);
    chk(fault_cause == 2'(ecause), req, "fault cause", fault_cause, ecause);
    last_cause = 2'(ecause);
  endtask

  task automatic cfg(input int o, input int c);
    c_open = CW'(o); c_close = CW'(c); load = 1'b1;
    tick();
    load = 1'b0;
  endtask

  initial begin
    int n;
    bit bad;
    tick(); tick();
    chk(wd_reset == 1'b0, "R10", "reset value of wd_reset", wd_reset, 0);
    chk(fault_cause == 2'b00, "R10", "reset value of fault_cause", fault_cause, 0);
    chk(cfg_error == 1'b0, "R10", "reset value of cfg_error", cfg_error, 0);
    rst_n = 1'b1;
    tick();

    // Sweep with default limits 6..12 (R10 defaults, R1/R2/R3)
    for (int d = 4; d <= 16; d++) begin
      if (d - 1 < 6)        trial(d, 2, 6, 12, 0, 0, "R2");
      else if (d - 1 <= 12) trial(d, 2, 6, 12, 0, 0, "R3");
      else                  trial(d, 2, 6, 12, 0, 0, "R1");
    end

    // R4: long-held kick gives one event, next fault is late not early
    trial(8, 20, 6, 12, 0, 0, "R4");

    // R5: halt for 20 edges shifts the late fault
    trial(99, 0, 6, 12, 2, 20, "R5");

    // R6: pulse length then restart from zero
    trial(99, 0, 6, 12, 0, 0, "R1");
    n = 0;
    for (int i = 0; i < 28; i++) begin
      if (wd_reset) n++;
      tick();
    end
    chk(n == PULSE, "R6", "pulse length", n, PULSE);
    chk(wd_reset == 1'b0, "R6", "low before restart fault", wd_reset, 0);
    tick();
    chk(wd_reset == 1'b1, "R6", "late fault after restart from zero", wd_reset, 1);

    // R9: disable mid-pulse
    en = 1'b0;
    tick();
    chk(wd_reset == 1'b0, "R9", "reset dropped when disabled", wd_reset, 0);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      if (wd_reset) bad = 1;
      tick();
    end
    chk(!bad, "R9", "no reset while disabled", bad, 0);
    chk(fault_cause == 2'b10, "R7", "cause held after pulse", fault_cause, 2);

    // R8: rejected configurations keep limits 6..12
    cfg(2, 2);
    chk(cfg_error == 1'b1, "R8", "equal limits rejected", cfg_error, 1);
    trial(5, 2, 6, 12, 0, 0, "R8");
    cfg(9, 3);
    chk(cfg_error == 1'b1, "R8", "reversed limits rejected", cfg_error, 1);
    trial(13, 2, 6, 12, 0, 0, "R8");
    cfg(2, 8);
    chk(cfg_error == 1'b0, "R8", "valid limits clear error", cfg_error, 0);
    trial(5, 2, 2, 8, 0, 0, "R8");
    trial(4, 2, 2, 8, 0, 0, "R3");
    trial(11, 2, 2, 8, 0, 0, "R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule